// File: doc/BRIEF.md
# SCSI Controller Command Queue

This block is the command-register front end of a SCSI protocol controller. A host writes and reads byte registers through a small offset/strobe bus. Command bytes go into a two-slot queue. The bottom slot is the command currently executing, and it is shown on `exec_valid_o`/`exec_cmd_o` to the sequencing logic that carries the command out. That logic reports completion with a one-cycle `cmd_done_i` pulse. NOP, Clear FIFO and Reset Bus complete by themselves one cycle after they reach the bottom slot.

Reset-class commands do not queue behind other work. They replace the queue contents and take the bottom slot. Reset Device also blocks the command register until a NOP runs. An overflowing write or an opcode the block does not know sets a sticky error bit. A command byte with its DMA bit set loads the working transfer counter from the programmed start count when it reaches the bottom slot. The load is 24 bits wide in extended mode and 16 bits wide otherwise.

Top module: `scsi_cmd_queue`

## Requirements
- R1: After `rst_ni` is released, the queue is empty (`exec_valid_o`=0), `clk_factor_o`=2, `sel_timeout_o`=0, and the status register (offset 4), the interrupt-status register (offset 5) and the command register (offset 3) all read 0.
- R2: A command byte written to offset 3 while the queue is empty and the lockout is clear is executing from the next cycle: `exec_valid_o`=1 and `exec_cmd_o` equals the byte. Bit 7 of the byte is the DMA flag and bits 6:0 are the opcode.
- R3: The queue holds two commands. A write made while both slots are occupied, with no completion in that cycle, is discarded and sets status bit 6 (status reads 0x40). After the bottom command completes, the waiting command moves to the bottom slot and executes.
- R4: Reset Bus (opcode 0x03) and DMA Stop (opcode 0x04) discard any queued commands and become the only entry, in the bottom slot, in the cycle after they are written.
- R5: Reset Device (opcode 0x02) empties the queue, clears both error bits, sets `clk_factor_o` to 2 and `sel_timeout_o` to 0, and engages the lockout, all in one clock.
- R6: While the lockout is engaged, every command write whose opcode is not 0 is ignored. A NOP (0x00 or 0x80) is accepted, and its completion releases the lockout.
- R7: An opcode outside {0x00–0x04, 0x10–0x1F} is removed from the queue one cycle after it reaches the bottom slot, and it sets interrupt-status bit 6 (reads 0x40).
- R8: NOP, Clear FIFO (0x01) and Reset Bus complete one cycle after reaching the bottom slot. `fifo_clr_o` is high in that cycle for Clear FIFO, and `bus_rst_o` is high in that cycle for Reset Bus. DMA Stop and opcodes 0x10–0x1F stay at the bottom until `cmd_done_i` is pulsed.
- R9: When a byte with bit 7 set reaches the bottom slot, the working counter loads the start count. The start count is written in bytes at offsets 0 (bits 7:0), 1 (bits 15:8) and 14 (bits 23:16). The load keeps all 24 bits when configuration bit 6 (offset 12) is set. Otherwise it keeps bits 15:0 and zeroes bits 23:16.
- R10: Reads at offsets 0 and 1 return working-counter bits 7:0 and 15:8. A read at offset 14 returns bits 23:16 only while configuration bit 6 is set, and returns 0 otherwise.
- R11: A read of offset 3 returns the byte in the bottom queue slot.
- R12: The status and interrupt-status error bits stay set until `rst_ni` is asserted or Reset Device is accepted.
- R13: Offset 5 writes `sel_timeout_o` and offset 9 writes `clk_factor_o`. Register reads are registered: `rd_data_o` updates on the clock edge where `reg_rd_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| cmd_done_i | input | 1 | Completion pulse for the executing command |
| exec_valid_o | output | 1 | A command occupies the bottom slot |
| exec_cmd_o | output | 8 | Bottom-slot command byte |
| fifo_clr_o | output | 1 | Clear FIFO completes this cycle |
| bus_rst_o | output | 1 | Reset Bus completes this cycle |
| clk_factor_o | output | 8 | Clock factor register |
| sel_timeout_o | output | 8 | Selection timeout register |

## Verification
The bench writes each of the 128 opcodes into an empty queue. For each one it checks whether the opcode finishes on its own, waits for a done pulse, locks the register or is flagged illegal. A design that misclassified an opcode would stall, retire a command early, or fail to flag it. The directed cases cover overflow, preemption by the reset class, and a lockout released by the DMA form of NOP. A queue that wrapped on overflow would run the third command, and one that ignored preemption would run stale entries. The counter is loaded once in standard mode and once in extended mode and then read back in both modes. A design that masked the counter only on readback, or not at all, would return a stale upper byte.

// File: rtl/scsi_cq_pkg.sv
package scsi_cq_pkg;
  localparam logic [6:0] OP_NOP     = 7'h00;
  localparam logic [6:0] OP_CLR     = 7'h01;
  localparam logic [6:0] OP_RSTDEV  = 7'h02;
  localparam logic [6:0] OP_RSTBUS  = 7'h03;
  localparam logic [6:0] OP_DMASTOP = 7'h04;

  localparam logic [3:0] A_CNT_LO  = 4'd0;
  localparam logic [3:0] A_CNT_MID = 4'd1;
  localparam logic [3:0] A_CMD     = 4'd3;
  localparam logic [3:0] A_STAT    = 4'd4;
  localparam logic [3:0] A_ISTAT   = 4'd5;  // write: selection timeout
  localparam logic [3:0] A_CLKF    = 4'd9;
  localparam logic [3:0] A_CFG     = 4'd12;
  localparam logic [3:0] A_CNT_HI  = 4'd14;

  localparam int CNT_W  = 24;
  localparam int STD_W  = 16;
  localparam int EXT_BIT = 6;

  typedef enum logic [1:0] {K_INST, K_WAIT, K_RESET_DEV, K_ILLEGAL} cmd_kind_e;

  function automatic cmd_kind_e classify(logic [6:0] op, logic [6:0] lo, logic [6:0] hi);
    if (op == OP_NOP || op == OP_CLR || op == OP_RSTBUS) return K_INST;
    if (op == OP_RSTDEV) return K_RESET_DEV;
    if (op == OP_DMASTOP || (op >= lo && op <= hi)) return K_WAIT;
    return K_ILLEGAL;
  endfunction
endpackage

// File: rtl/scsi_cq_ctrl.sv
module scsi_cq_ctrl
  import scsi_cq_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter logic [6:0] LONG_LO = 7'h10,
  parameter logic [6:0] LONG_HI = 7'h1F,
  localparam int QC_W = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_wr_i,
  input  logic [7:0]      cmd_i,
  input  logic            done_i,
  output logic [7:0]      bottom_o,
  output logic [QC_W-1:0] q_cnt_o,
  output logic            lock_o,
  output logic            gross_o,
  output logic            icmd_o,
  output logic            dev_rst_o,
  output logic            enter_o,
  output logic [7:0]      enter_byte_o,
  output logic            fifo_clr_o,
  output logic            bus_rst_o
);
  localparam logic [QC_W-1:0] DEPTH_C = QC_W'(DEPTH);

  logic [7:0]      q_q [DEPTH];
  logic [7:0]      q_n [DEPTH];
  logic [QC_W-1:0] cnt_q, cnt_n, cnt_pop;
  logic            lock_q, lock_n, gross_q, gross_n, icmd_q, icmd_n;
  logic            busy, fin, wr_ok, enter;
  logic [7:0]      enter_byte;
  cmd_kind_e       k0, kw;

  assign busy = (cnt_q != '0);
  assign k0   = classify(q_q[0][6:0], LONG_LO, LONG_HI);
  assign kw   = classify(cmd_i[6:0], LONG_LO, LONG_HI);
  assign fin  = busy && (k0 != K_WAIT || done_i);
  assign wr_ok = cmd_wr_i && (!lock_q || cmd_i[6:0] == OP_NOP);
  assign dev_rst_o = wr_ok && kw == K_RESET_DEV;

  always_comb begin
    q_n        = q_q;
    cnt_pop    = cnt_q;
    enter      = 1'b0;
    enter_byte = q_q[1];
    lock_n     = lock_q;
    gross_n    = gross_q;
    icmd_n     = icmd_q;
    if (fin) begin
      for (int i = 0; i < DEPTH - 1; i++) q_n[i] = q_q[i+1];
      cnt_pop = cnt_q - QC_W'(1);
      if (cnt_q > QC_W'(1)) enter = 1'b1;
      if (k0 == K_ILLEGAL) icmd_n = 1'b1;
      if (q_q[0][6:0] == OP_NOP) lock_n = 1'b0;
    end
    cnt_n = cnt_pop;
    if (wr_ok) begin
      if (kw == K_RESET_DEV || cmd_i[6:0] == OP_RSTBUS || cmd_i[6:0] == OP_DMASTOP) begin
        // reset class: drop queue, occupy bottom slot
        q_n[0]     = cmd_i;
        cnt_n      = (kw == K_RESET_DEV) ? '0 : QC_W'(1);
        enter      = 1'b1;
        enter_byte = cmd_i;
        if (kw == K_RESET_DEV) begin
          lock_n  = 1'b1;
          gross_n = 1'b0;
          icmd_n  = 1'b0;
        end
      end else if (cnt_pop < DEPTH_C) begin
        for (int i = 0; i < DEPTH; i++)
          if (cnt_pop == QC_W'(i)) q_n[i] = cmd_i;
        if (cnt_pop == '0) begin
          enter      = 1'b1;
          enter_byte = cmd_i;
        end
        cnt_n = cnt_pop + QC_W'(1);
      end else begin
        gross_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) q_q[i] <= '0;
      cnt_q   <= '0;
      lock_q  <= 1'b0;
      gross_q <= 1'b0;
      icmd_q  <= 1'b0;
    end else begin
      q_q     <= q_n;
      cnt_q   <= cnt_n;
      lock_q  <= lock_n;
      gross_q <= gross_n;
      icmd_q  <= icmd_n;
    end
  end

  assign bottom_o     = q_q[0];
  assign q_cnt_o      = cnt_q;
  assign lock_o       = lock_q;
  assign gross_o      = gross_q;
  assign icmd_o       = icmd_q;
  assign enter_o      = enter;
  assign enter_byte_o = enter_byte;
  assign fifo_clr_o   = busy && q_q[0][6:0] == OP_CLR;
  assign bus_rst_o    = busy && q_q[0][6:0] == OP_RSTBUS;
endmodule

// File: rtl/scsi_cq_xfer.sv
module scsi_cq_xfer
  import scsi_cq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [3:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             ext_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int NBYTE = CNT_W / 8;
  localparam logic [CNT_W-1:0] STD_MASK = CNT_W'((1 << STD_W) - 1);

  logic [CNT_W-1:0] start_q, work_q;

  function automatic logic [3:0] byte_addr(int b);
    case (b)
      0:       return A_CNT_LO;
      1:       return A_CNT_MID;
      default: return A_CNT_HI;
    endcase
  endfunction

  for (genvar b = 0; b < NBYTE; b++) begin : g_start
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) start_q[8*b +: 8] <= '0;
      else if (wr_i && addr_i == byte_addr(b)) start_q[8*b +: 8] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) work_q <= '0;
    else if (load_i) work_q <= ext_i ? start_q : (start_q & STD_MASK);
  end

  assign count_o = work_q;
endmodule

// File: rtl/scsi_cmd_queue.sv
module scsi_cmd_queue
  import scsi_cq_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter logic [6:0] LONG_LO = 7'h10,
  parameter logic [6:0] LONG_HI = 7'h1F,
  localparam int QC_W = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] reg_addr_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] rd_data_o,
  input  logic       cmd_done_i,
  output logic       exec_valid_o,
  output logic [7:0] exec_cmd_o,
  output logic       fifo_clr_o,
  output logic       bus_rst_o,
  output logic [7:0] clk_factor_o,
  output logic [7:0] sel_timeout_o
);
  logic [QC_W-1:0]  q_cnt;
  logic [7:0]       bottom, enter_byte, cfg_q;
  logic             lock_q, gross_q, icmd_q, dev_rst, enter, ext;
  logic [CNT_W-1:0] xcnt;

  assign ext = cfg_q[EXT_BIT];

  scsi_cq_ctrl #(.DEPTH(DEPTH), .LONG_LO(LONG_LO), .LONG_HI(LONG_HI)) ctrl_i (
    .clk_i, .rst_ni,
    .cmd_wr_i    (reg_wr_i && reg_addr_i == A_CMD),
    .cmd_i       (reg_wdata_i),
    .done_i      (cmd_done_i),
    .bottom_o    (bottom),
    .q_cnt_o     (q_cnt),
    .lock_o      (lock_q),
    .gross_o     (gross_q),
    .icmd_o      (icmd_q),
    .dev_rst_o   (dev_rst),
    .enter_o     (enter),
    .enter_byte_o(enter_byte),
    .fifo_clr_o  (fifo_clr_o),
    .bus_rst_o   (bus_rst_o)
  );

  scsi_cq_xfer xfer_i (
    .clk_i, .rst_ni,
    .wr_i   (reg_wr_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .ext_i  (ext),
    .load_i (enter && enter_byte[7]),
    .count_o(xcnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_factor_o  <= 8'd2;
      sel_timeout_o <= '0;
      cfg_q         <= '0;
    end else begin
      if (dev_rst) begin
        clk_factor_o  <= 8'd2;
        sel_timeout_o <= '0;
      end else if (reg_wr_i) begin
        if (reg_addr_i == A_CLKF)  clk_factor_o  <= reg_wdata_i;
        if (reg_addr_i == A_ISTAT) sel_timeout_o <= reg_wdata_i;
      end
      if (reg_wr_i && reg_addr_i == A_CFG) cfg_q <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else if (reg_rd_i) begin
      case (reg_addr_i)
        A_CNT_LO:  rd_data_o <= xcnt[7:0];
        A_CNT_MID: rd_data_o <= xcnt[15:8];
        A_CNT_HI:  rd_data_o <= ext ? xcnt[23:16] : 8'h00;
        A_CMD:     rd_data_o <= bottom;
        A_STAT:    rd_data_o <= {1'b0, gross_q, 6'b0};
        A_ISTAT:   rd_data_o <= {1'b0, icmd_q, 6'b0};
        A_CFG:     rd_data_o <= cfg_q;
        default:   rd_data_o <= 8'h00;
      endcase
    end
  end

  assign exec_valid_o = (q_cnt != '0);
  assign exec_cmd_o   = bottom;
endmodule

// File: rtl/scsi_cmd_queue_chk.sv
module scsi_cmd_queue_chk
  import scsi_cq_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter logic [6:0] LONG_LO = 7'h10,
  parameter logic [6:0] LONG_HI = 7'h1F,
  localparam int QC_W = $clog2(DEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [3:0]      reg_addr_i,
  input logic            reg_wr_i,
  input logic [7:0]      reg_wdata_i,
  input logic            cmd_done_i,
  input logic            exec_valid_o,
  input logic [7:0]      exec_cmd_o,
  input logic [QC_W-1:0] q_cnt,
  input logic            lock_q,
  input logic            gross_q,
  input logic            icmd_q
);
  localparam logic [QC_W-1:0] DEPTH_C = QC_W'(DEPTH);
  logic      cmd_wr, dev_acc;
  cmd_kind_e k0;
  assign cmd_wr  = reg_wr_i && reg_addr_i == A_CMD;
  assign dev_acc = cmd_wr && !lock_q && reg_wdata_i[6:0] == OP_RSTDEV;
  assign k0      = classify(exec_cmd_o[6:0], LONG_LO, LONG_HI);

  a_r3_depth: assert property (@(posedge clk_i) disable iff (!rst_ni) q_cnt <= DEPTH_C);
  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_valid_o && cmd_wr && !lock_q && reg_wdata_i[6:0] != OP_RSTDEV)
    |=> (exec_valid_o && exec_cmd_o == $past(reg_wdata_i)));
  a_r5_dev_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_acc |=> (!exec_valid_o && lock_q && !gross_q && !icmd_q));
  a_r6_lock_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !exec_valid_o && cmd_wr && reg_wdata_i[6:0] != OP_NOP) |=> !exec_valid_o);
  a_r7_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_valid_o && k0 == K_ILLEGAL) |=> icmd_q);
  a_r8_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_valid_o && k0 == K_WAIT && !cmd_done_i && !cmd_wr)
    |=> (exec_valid_o && $stable(exec_cmd_o)));
  a_r12_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gross_q && !dev_acc) |=> gross_q);
endmodule

bind scsi_cmd_queue scsi_cmd_queue_chk #(.DEPTH(DEPTH), .LONG_LO(LONG_LO), .LONG_HI(LONG_HI)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
  .reg_wdata_i(reg_wdata_i), .cmd_done_i(cmd_done_i), .exec_valid_o(exec_valid_o),
  .exec_cmd_o(exec_cmd_o), .q_cnt(q_cnt), .lock_q(lock_q), .gross_q(gross_q), .icmd_q(icmd_q)
);

// File: tb/scsi_cmd_queue_tb.sv
module scsi_cmd_queue_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] reg_addr_i = '0;
  logic       reg_wr_i = 1'b0, reg_rd_i = 1'b0, cmd_done_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] rd_data_o, exec_cmd_o, clk_factor_o, sel_timeout_o;
  logic       exec_valid_o, fifo_clr_o, bus_rst_o;
  int         errors = 0, checks = 0;
  bit         finished = 1'b0;

  always #2 clk_i = ~clk_i;

  scsi_cmd_queue dut_i (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FIFO FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk_i); endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk_i); reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_wr_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i); reg_rd_i = 1'b1; reg_addr_i = a;
    @(negedge clk_i); reg_rd_i = 1'b0; d = rd_data_o;
  endtask

  task automatic done();
    @(negedge clk_i); cmd_done_i = 1'b1;
    @(negedge clk_i); cmd_done_i = 1'b0;
  endtask

  // Reset Device then NOP: clears flags and lockout
  task automatic clean();
    wr(4'd3, 8'h02); wr(4'd3, 8'h00); tick();
  endtask

  function automatic int kind(int op);
    if (op == 0 || op == 1 || op == 3) return 0;       // completes by itself
    if (op == 2) return 2;                             // reset device
    if (op == 4 || (op >= 16 && op <= 31)) return 1;   // waits for done
    return 3;                                          // illegal
  endfunction

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    tick(); tick(); rst_ni = 1'b1; tick();
    // R1 reset state
    chk("R1 exec_valid", exec_valid_o, 0);
    chk("R1 clk_factor", clk_factor_o, 2);
    chk("R1 sel_timeout", sel_timeout_o, 0);
    rd(4'd4, d); chk("R1 status", d, 0);
    rd(4'd5, d); chk("R1 istat", d, 0);
    rd(4'd3, d); chk("R1 cmd", d, 0);

    // opcode sweep R2 R7 R8 R6
    for (int op = 0; op < 128; op++) begin
      int k;
      k = kind(op);
      wr(4'd3, 8'(op));
      if (k == 2) begin
        chk("R5 dev empties", exec_valid_o, 0);
        wr(4'd3, 8'h10); chk("R6 locked ignore", exec_valid_o, 0);
        wr(4'd3, 8'h80); chk("R6 dma nop accepted", exec_valid_o, 1);
        tick(); chk("R6 nop completes", exec_valid_o, 0);
        wr(4'd3, 8'h10); chk("R6 unlocked", exec_valid_o, 1);
        done(); chk("R6 done", exec_valid_o, 0);
      end else begin
        chk("R2 exec_valid", exec_valid_o, 1);
        chk("R2 exec_cmd", exec_cmd_o, op);
        if (op == 1) chk("R8 fifo_clr", fifo_clr_o, 1);
        if (op == 3) chk("R8 bus_rst", bus_rst_o, 1);
        if (k == 1) begin
          tick(); chk("R8 waits for done", exec_valid_o, 1);
          done(); chk("R8 done retires", exec_valid_o, 0);
        end else begin
          tick(); chk("R8/R7 one-cycle retire", exec_valid_o, 0);
        end
        rd(4'd5, d); chk("R7 istat", d, (k == 3) ? 8'h40 : 8'h00);
        if (k == 3) begin
          tick(); rd(4'd5, d); chk("R12 istat sticky", d, 8'h40);
          clean(); rd(4'd5, d); chk("R5 istat cleared", d, 0);
        end
      end
    end

    // R3 overflow and ordering, R11 readback
    wr(4'd3, 8'h10); wr(4'd3, 8'h11); wr(4'd3, 8'h12);
    rd(4'd4, d); chk("R3 gross error", d, 8'h40);
    rd(4'd3, d); chk("R11 cmd readback", d, 8'h10);
    done(); chk("R3 second promoted", exec_cmd_o, 8'h11);
    chk("R3 still valid", exec_valid_o, 1);
    done(); chk("R3 overflow dropped", exec_valid_o, 0);
    rd(4'd4, d); chk("R12 status sticky", d, 8'h40);

    // R4 preemption
    wr(4'd3, 8'h10); wr(4'd3, 8'h11); wr(4'd3, 8'h04);
    chk("R4 dma stop bottom", exec_cmd_o, 8'h04);
    done(); chk("R4 queue discarded", exec_valid_o, 0);
    wr(4'd3, 8'h10); wr(4'd3, 8'h03);
    chk("R4 reset bus bottom", exec_cmd_o, 8'h03);
    chk("R8 bus_rst pulse", bus_rst_o, 1);
    tick(); chk("R4 reset bus only", exec_valid_o, 0);

    // R13 / R5 config regs
    wr(4'd9, 8'h05); wr(4'd5, 8'h33);
    chk("R13 clk_factor", clk_factor_o, 5);
    chk("R13 sel_timeout", sel_timeout_o, 8'h33);
    wr(4'd3, 8'h02);
    chk("R5 clk_factor", clk_factor_o, 2);
    chk("R5 sel_timeout", sel_timeout_o, 0);
    rd(4'd4, d); chk("R5 status cleared", d, 0);
    wr(4'd3, 8'h00); tick();

    // R9 R10 counter load
    wr(4'd0, 8'h56); wr(4'd1, 8'h34); wr(4'd14, 8'h12);
    wr(4'd12, 8'h40); wr(4'd3, 8'h90); done();
    rd(4'd14, d); chk("R9 ext hi", d, 8'h12);
    rd(4'd0, d); chk("R10 lo", d, 8'h56);
    rd(4'd1, d); chk("R10 mid", d, 8'h34);
    wr(4'd12, 8'h00);
    rd(4'd14, d); chk("R10 hi gated", d, 0);
    wr(4'd3, 8'h90); done();
    wr(4'd12, 8'h40);
    rd(4'd14, d); chk("R9 std load truncated", d, 0);
    rd(4'd0, d); chk("R9 std lo", d, 8'h56);
    wr(4'd0, 8'h99); wr(4'd3, 8'h10); done();
    rd(4'd0, d); chk("R9 non-dma no load", d, 8'h56);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule